// File: doc/BRIEF.md
# Frame-Clock Ratio Detector

This block works out which of eight supported bit-clock rates is present. It does this by counting bit-clock cycles between two rising edges of the 8 kHz frame sync. The frame sync is synchronous to the bit clock, and the bit clock itself drives the counter. The supported rates run from 256 kHz to 8.192 MHz, which gives 32 to 1024 cycles per frame.

After reset, the first complete frame that matches one of the eight counts is turned into a 3-bit selector and latched without any register write. The block also outputs the factor that a downstream clock synthesizer must apply to bring the bit clock up to 16.384 MHz. Two of these factors are not whole numbers, so they carry a fractional flag.

The block waits 64 bit-clock cycles after latching, which matches the expected synthesizer settling time, and then raises the valid flag. A count that fits none of the rates, or a frame sync that never arrives, raises the error flag instead.

Top module: `frame_ratio_detect`

## Requirements
- R1: While reset is held and just after it is released, mult_code is 0, mult_int is 64, mult_frac is 0, ratio_valid is 0 and ratio_err is 0.
- R2: A measurement covers only the cycles between two consecutive synchronized rising edges of fsync. The partial interval from reset release to the first edge is discarded.
- R3: A measured count of 32, 64, 96, 128, 192, 256, 512 or 1024 cycles latches mult_code 0, 1, 2, 3, 4, 5, 6 or 7, in that order. The new code is visible 3 clock edges after the edge that first samples the second fsync high.
- R4: mult_int gives the integer part of 2048 divided by the count for the current code: 64, 32, 21, 16, 10, 8, 4 and 2 for codes 0 to 7. mult_frac is 1 only for codes 2 and 4, where the division leaves a remainder.
- R5: ratio_valid rises exactly 64 clock edges after the edge that latches the code. It is still 0 one edge earlier.
- R6: A measured count that is not one of the eight values sets ratio_err, with the same timing as R3. ratio_valid then stays 0 and mult_code stays 0 until reset.
- R7: Once latched, mult_code and ratio_valid hold, whatever later frames measure, until the next reset.
- R8: The interval counter saturates at 2047 and never wraps. If no second fsync edge arrives, ratio_err rises once the count saturates, while valid and code stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit clock; clocks all logic |
| rst_n | input | 1 | Active-low reset, synchronous to clk_bit |
| fsync | input | 1 | 8 kHz frame sync |
| mult_code | output | 3 | Latched rate selector |
| mult_int | output | 7 | Integer part of the synthesizer multiplier |
| mult_frac | output | 1 | Multiplier has a fractional part |
| ratio_valid | output | 1 | Code latched and settle wait elapsed |
| ratio_err | output | 1 | Unsupported or saturated interval seen |

## Verification
Time is counted from the clock edge that first samples the closing fsync edge high. That edge is followed by two synchronizer stages and then the measurement strobe, so the code or error is due after the third edge, and valid is due after the 67th edge. The bench drives fsync on falling edges and counts falling edges from that point. It samples one edge before each due point, to see the old value, and at the due point, to see the new one. The saturation case waits well past 2047 cycles from a single edge. It first checks that a 1030-cycle gap has raised no error.

// File: rtl/frame_ratio_pkg.sv
package frame_ratio_pkg;
  localparam int NUM_RATES    = 8;
  localparam int CODE_W       = $clog2(NUM_RATES);
  localparam int BASE_CNT     = 32;
  localparam int TARGET_RATIO = 2048;  // 16.384 MHz / 8 kHz
  localparam int FACT_W       = $clog2(TARGET_RATIO / BASE_CNT) + 1;

  typedef enum logic [1:0] {ST_MEASURE, ST_SETTLE, ST_LOCKED, ST_FAULT} ctl_state_t;

  // Multiples of the lowest rate, ascending with the code.
  function automatic int rate_mult(input int idx);
    case (idx)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 4;
      4: return 6;
      5: return 8;
      6: return 16;
      default: return 32;
    endcase
  endfunction

  function automatic int expected_count(input int idx);
    return BASE_CNT * rate_mult(idx);
  endfunction

  function automatic logic [FACT_W-1:0] factor_int(input logic [CODE_W-1:0] code);
    return FACT_W'(TARGET_RATIO / expected_count(int'(code)));
  endfunction

  function automatic logic factor_frac(input logic [CODE_W-1:0] code);
    return (TARGET_RATIO % expected_count(int'(code))) != 0;
  endfunction
endpackage

// File: rtl/fsync_edge.sv
module fsync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= fsync_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;

  // R2: an edge is a single-cycle event
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/period_counter.sv
module period_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  output logic             meas_stb_o,
  output logic [CNT_W-1:0] meas_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             armed_q, sat_seen_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      sat_seen_q <= 1'b0;
      cnt_q      <= '0;
      meas_stb_o <= 1'b0;
      meas_o     <= '0;
    end else begin
      meas_stb_o <= 1'b0;
      if (rise_i) begin
        if (armed_q) begin
          meas_stb_o <= 1'b1;
          meas_o     <= cnt_q;
        end
        armed_q    <= 1'b1;
        sat_seen_q <= 1'b0;
        cnt_q      <= CNT_W'(1);
      end else if (armed_q) begin
        if (cnt_q == CNT_MAX) begin
          if (!sat_seen_q) begin
            meas_stb_o <= 1'b1;
            meas_o     <= cnt_q;
            sat_seen_q <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  // R8: the counter never wraps past its ceiling
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !rise_i) |=> (cnt_q == CNT_MAX));
  // R2: no measurement before the counter has seen a first edge
  a_r2_no_partial: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !rise_i) |=> !meas_stb_o);
endmodule

// File: rtl/rate_match.sv
module rate_match
  import frame_ratio_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  meas_i,
  output logic              hit_o,
  output logic [CODE_W-1:0] code_o
);
  logic [NUM_RATES-1:0] hit_vec;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_cmp
    assign hit_vec[g] = (meas_i == CNT_W'(expected_count(g)));
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (hit_vec[i]) code_o = CODE_W'(i);
    end
  end

  assign hit_o = |hit_vec;

  // R3: at most one rate matches any count
  a_r3_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/frame_ratio_detect.sv
module frame_ratio_detect
  import frame_ratio_pkg::*;
#(
  parameter int CNT_W      = 11,
  parameter int SETTLE_CYC = 64
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              fsync,
  output logic [CODE_W-1:0] mult_code,
  output logic [FACT_W-1:0] mult_int,
  output logic              mult_frac,
  output logic              ratio_valid,
  output logic              ratio_err
);
  localparam int WAIT_W = $clog2(SETTLE_CYC);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(SETTLE_CYC - 1);

  logic              rise;
  logic              meas_stb;
  logic [CNT_W-1:0]  meas;
  logic              hit;
  logic [CODE_W-1:0] match_code;
  ctl_state_t        state_q;
  logic [WAIT_W-1:0] wait_q;

  fsync_edge u_edge (
    .clk(clk_bit), .rst_n(rst_n), .fsync_i(fsync), .rise_o(rise)
  );

  period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk_bit), .rst_n(rst_n), .rise_i(rise),
    .meas_stb_o(meas_stb), .meas_o(meas)
  );

  rate_match #(.CNT_W(CNT_W)) u_match (
    .clk(clk_bit), .rst_n(rst_n), .meas_i(meas),
    .hit_o(hit), .code_o(match_code)
  );

  always_ff @(posedge clk_bit) begin
    if (!rst_n) begin
      state_q     <= ST_MEASURE;
      mult_code   <= '0;
      wait_q      <= '0;
      ratio_valid <= 1'b0;
      ratio_err   <= 1'b0;
    end else begin
      case (state_q)
        ST_MEASURE: if (meas_stb) begin
          if (hit) begin
            mult_code <= match_code;
            wait_q    <= '0;
            state_q   <= ST_SETTLE;
          end else begin
            ratio_err <= 1'b1;
            state_q   <= ST_FAULT;
          end
        end
        ST_SETTLE: begin
          if (wait_q == WAIT_LAST) begin
            ratio_valid <= 1'b1;
            state_q     <= ST_LOCKED;
          end else begin
            wait_q <= wait_q + WAIT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign mult_int  = factor_int(mult_code);
  assign mult_frac = factor_frac(mult_code);

  // R3: a matching strobe latches the matched code
  a_r3_latch_code: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (state_q == ST_MEASURE && meas_stb && hit) |=> (mult_code == $past(match_code)));
  // R5: valid never comes before the settle count ends
  a_r5_no_early_valid: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (state_q == ST_SETTLE && wait_q != WAIT_LAST) |=> !ratio_valid);
  // R6: an error excludes valid and a nonzero code
  a_r6_err_exclusive: assert property (@(posedge clk_bit) disable iff (!rst_n)
    ratio_err |-> (!ratio_valid && mult_code == '0));
  // R7: a locked code never moves
  a_r7_frozen: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (state_q == ST_LOCKED) |=> ($stable(mult_code) && ratio_valid));
endmodule

// File: tb/sim_frame_ratio_detect.sv
module sim_frame_ratio_detect;
  logic       clk_bit = 1'b0;
  logic       rst_n   = 1'b0;
  logic       fsync   = 1'b0;
  logic [2:0] mult_code;
  logic [6:0] mult_int;
  logic       mult_frac;
  logic       ratio_valid;
  logic       ratio_err;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  // Bench's own table: counts per frame, multiplier integer part, fraction flag
  int cnt_tab [8] = '{32, 64, 96, 128, 192, 256, 512, 1024};
  int int_tab [8] = '{64, 32, 21, 16, 10, 8, 4, 2};
  int frac_tab[8] = '{0, 0, 1, 0, 1, 0, 0, 0};

  frame_ratio_detect u0 (
    .clk_bit(clk_bit), .rst_n(rst_n), .fsync(fsync),
    .mult_code(mult_code), .mult_int(mult_int), .mult_frac(mult_frac),
    .ratio_valid(ratio_valid), .ratio_err(ratio_err)
  );

  always #5 clk_bit = ~clk_bit;

  always @(posedge clk_bit) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_bit);
    rst_n = 1'b0;
    fsync = 1'b0;
    repeat (4) @(negedge clk_bit);
    chk("R1 code", int'(mult_code), 0);
    chk("R1 int", int'(mult_int), 64);
    chk("R1 frac", int'(mult_frac), 0);
    chk("R1 valid", int'(ratio_valid), 0);
    chk("R1 err", int'(ratio_err), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_bit);
  endtask

  // Ends at the falling edge right after the sampling edge of the pulse.
  task automatic pulse();
    fsync = 1'b1;
    @(negedge clk_bit);
    fsync = 1'b0;
  endtask

  // Two edges n cycles apart; returns after the sampling edge of the second.
  task automatic frame_pair(input int n);
    pulse();
    repeat (n - 1) @(negedge clk_bit);
    pulse();
  endtask

  task automatic t_rate(input int idx);
    do_reset();
    frame_pair(cnt_tab[idx]);
    repeat (2) @(negedge clk_bit);
    // R3: not yet latched after the second edge
    chk("R3 early valid", int'(ratio_valid), 0);
    chk("R3 early err", int'(ratio_err), 0);
    @(negedge clk_bit);
    chk("R3 code", int'(mult_code), idx);
    chk("R4 int", int'(mult_int), int_tab[idx]);
    chk("R4 frac", int'(mult_frac), frac_tab[idx]);
    repeat (63) @(negedge clk_bit);
    chk("R5 valid one edge early", int'(ratio_valid), 0);
    @(negedge clk_bit);
    chk("R5 valid", int'(ratio_valid), 1);
    chk("R5 err", int'(ratio_err), 0);
  endtask

  // R2: reset-to-first-edge interval is not measured
  task automatic t_partial();
    do_reset();
    repeat (40) @(negedge clk_bit);
    pulse();
    repeat (200) @(negedge clk_bit);
    chk("R2 one edge no err", int'(ratio_err), 0);
    chk("R2 one edge no valid", int'(ratio_valid), 0);
    do_reset();
    repeat (40) @(negedge clk_bit);
    frame_pair(64);
    repeat (3) @(negedge clk_bit);
    chk("R2 code from full frame", int'(mult_code), 1);
    chk("R2 no err", int'(ratio_err), 0);
  endtask

  task automatic t_bad(input int n);
    do_reset();
    frame_pair(n);
    repeat (2) @(negedge clk_bit);
    chk("R6 err early", int'(ratio_err), 0);
    @(negedge clk_bit);
    chk("R6 err", int'(ratio_err), 1);
    chk("R6 code", int'(mult_code), 0);
    repeat (80) @(negedge clk_bit);
    chk("R6 valid stays low", int'(ratio_valid), 0);
    chk("R6 err sticky", int'(ratio_err), 1);
  endtask

  task automatic t_freeze();
    do_reset();
    frame_pair(128);
    repeat (70) @(negedge clk_bit);
    chk("R7 locked code", int'(mult_code), 3);
    for (int k = 0; k < 3; k++) begin
      repeat (63) @(negedge clk_bit);
      pulse();
    end
    frame_pair(100);
    repeat (10) @(negedge clk_bit);
    chk("R7 code frozen", int'(mult_code), 3);
    chk("R7 valid held", int'(ratio_valid), 1);
    chk("R7 no err", int'(ratio_err), 0);
  endtask

  task automatic t_sat();
    do_reset();
    pulse();
    repeat (1030) @(negedge clk_bit);
    chk("R8 no err before ceiling", int'(ratio_err), 0);
    repeat (1100) @(negedge clk_bit);
    chk("R8 err on saturation", int'(ratio_err), 1);
    chk("R8 valid low", int'(ratio_valid), 0);
    chk("R8 code zero", int'(mult_code), 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) t_rate(i);
    t_partial();
    t_bad(100);
    t_bad(33);
    t_freeze();
    t_sat();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule